// File: doc/BRIEF.md
# Windowed Watchdog Timer

A register-programmed supervisory timer that counts down on a prescaled count clock and must be serviced by software inside a programmable window of its period. Counting is dormant after reset and begins only when a two-write service sequence (a 00h write, then an FFh write, both to the service register) is issued. Repeating the same sequence while running reloads the full period, provided the remaining count lies inside the window.

When the counter runs out, or when the service sequence is malformed or lands outside the window, a sticky status flag is raised. A single response-select bit then routes the condition to either a reset-request output or an interrupt output. A debug stop bit, or the external debug-stop input, freezes counting without losing the count. Once counting has started, the control register is locked until the next reset, so the period, the divider and the window cannot be altered while the timer is running.

Top module: `win_watchdog`

## Requirements
- R1: After reset the status register reads 0000h (count 0, both flags clear), both `rst_req` and `irq` are low, and the counter stays at 0 however many count-clock enables arrive.
- R2: A write of 00h to the service register (address 0) followed directly by a write of FFh starts counting and loads the reload value chosen by control bits [1:0]: 00 gives 03FFh, 01 gives 0FFFh, 10 gives 1FFFh and 11 gives 3FFFh. The count then drops by one per prescaled tick.
- R3: Control bits [7:4] pick the divider applied to `cnt_tick`: 0000 divides by 1, 0100 by 4, 0101 by 256 and 1000 by 8192, and every other code divides by 1. The prescaler restarts from zero on every accepted service.
- R4: With period P, start code S in control bits [13:12] and end code E in control bits [9:8], a service is inside the window when 4·count < P·(S+1) and 4·count ≥ P·(3−E). S codes 00, 01, 10 and 11 mean 25%, 50%, 75% and 100%. E codes 00, 01, 10 and 11 mean 75%, 50%, 25% and 0%. A running service inside the window reloads the counter.
- R5: A complete service sequence issued while running and outside the window sets the refresh-error flag (status bit 15) and leaves the count unchanged. When the start position lies below the end position, every running service is an error.
- R6: An FFh write to the service register that does not directly follow a 00h write to it sets the refresh-error flag. This includes a write that follows another value.
- R7: A prescaled tick that arrives while the count is 0 sets the underflow flag (status bit 14) and reloads the period.
- R8: Bit 7 of the response register (address 3) routes a set flag: when it is 1, `rst_req` is high while either flag is set, and when it is 0, `irq` is high instead. The two outputs are never high together.
- R9: The flags are sticky. A write to the status register (address 2) clears each flag whose data bit is 0 and keeps each flag whose data bit is 1. Status bits [13:0] read the current count.
- R10: While bit 0 of the debug register (address 4) is 1, or `dbg_halt` is high, the count holds its value. Counting resumes from that value when both are low.
- R11: Before counting starts, the control register (address 1) reads back the written value masked to its fields (mask 33F3h). After the first accepted service, writes to it are ignored until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (3) | Register address |
| bus_wdata | input | DATA_W (16) | Write data; the service register uses bits [7:0] |
| bus_rdata | output | DATA_W (16) | Read data for `bus_addr`, combinational |
| cnt_tick | input | 1 | Count-clock enable, one pulse per count-clock period |
| dbg_halt | input | 1 | Debug-stop request; freezes counting while high |
| rst_req | output | 1 | Reset request while a flag is set and the response bit is 1 |
| irq | output | 1 | Interrupt while a flag is set and the response bit is 0 |

## Verification
The window check is exercised with random start and end codes and random service times across the whole 1024-cycle period. This separates a one-off slip at either window edge from a swapped or inverted position decode, and the empty-window setting isolates the ordering of the two limits. Directed patterns cover the rest. Malformed sequences (a bare FFh, and an FFh after a different value) distinguish the arming logic from the window logic. Long tick runs on each divider code and each period code tell the prescaler decode apart from the reload decode. Underflow at exactly count 0, freeze by register and by pin, and flag clearing with mixed 0/1 data bits each isolate one path.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;
   localparam int CNT_W = 14;
   localparam int PRE_W = 13;
   localparam logic [15:0] CTRL_MASK = 16'h33F3;

   function automatic logic [CNT_W-1:0] wwdt_reload(input logic [1:0] tops);
      case (tops)
         2'b00:   return CNT_W'(16'h03FF);
         2'b01:   return CNT_W'(16'h0FFF);
         2'b10:   return CNT_W'(16'h1FFF);
         default: return CNT_W'(16'h3FFF);
      endcase
   endfunction

   function automatic logic [PRE_W-1:0] wwdt_div_m1(input logic [3:0] cks);
      case (cks)
         4'b0100: return PRE_W'(3);
         4'b0101: return PRE_W'(255);
         4'b1000: return PRE_W'(8191);
         default: return PRE_W'(0);
      endcase
   endfunction
endpackage

// File: rtl/wwdt_prescale.sv
module wwdt_prescale #(
   parameter int PRE_W = wwdt_pkg::PRE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic [PRE_W-1:0] div_m1,
   output logic             tick
);
   logic [PRE_W-1:0] pre_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pre_q <= '0;
      else if (clr)        pre_q <= '0;
      else if (en) begin
         if (pre_q >= div_m1) pre_q <= '0;
         else                 pre_q <= pre_q + 1'b1;
      end
   end

   assign tick = en && (pre_q >= div_m1);

   // R3: the phase counter never passes the selected ratio
   a_r3_pre_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> pre_q <= div_m1);
endmodule

// File: rtl/wwdt_window.sv
module wwdt_window #(
   parameter int CNT_W = wwdt_pkg::CNT_W
) (
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] reload,
   input  logic [1:0]       wst,
   input  logic [1:0]       wend,
   output logic             legal
);
   localparam int EW = CNT_W + 2;
   logic [EW-1:0] qtr, slim, elim, cnt_x;

   always_comb begin
      qtr   = ({2'b00, reload} + EW'(1)) >> 2;
      cnt_x = {2'b00, cnt};
      case (wst)
         2'd0:    slim = qtr;
         2'd1:    slim = qtr << 1;
         2'd2:    slim = qtr + (qtr << 1);
         default: slim = qtr << 2;
      endcase
      slim = slim - EW'(1);
      case (wend)
         2'd0:    elim = qtr + (qtr << 1);
         2'd1:    elim = qtr << 1;
         2'd2:    elim = qtr;
         default: elim = '0;
      endcase
      legal = (cnt_x <= slim) && (cnt_x >= elim);
   end
endmodule

// File: rtl/wwdt_refresh_seq.sv
module wwdt_refresh_seq (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_svc,
   input  logic [7:0] svc_byte,
   output logic       seq_done,
   output logic       stray
);
   logic armed_q;
   logic is_ff;

   assign is_ff    = (svc_byte == 8'hFF);
   assign seq_done = wr_svc && is_ff && armed_q;
   assign stray    = wr_svc && is_ff && !armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      armed_q <= 1'b0;
      else if (wr_svc) armed_q <= (svc_byte == 8'h00);
   end

   // R2: a completed sequence always disarms
   a_r2_disarm: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |=> !armed_q);
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog #(
   parameter int ADDR_W   = 3,
   parameter int DATA_W   = 16,
   parameter bit SYNC_DBG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              cnt_tick,
   input  logic              dbg_halt,
   output logic              rst_req,
   output logic              irq
);
   import wwdt_pkg::*;

   localparam logic [ADDR_W-1:0] A_SVC  = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(2);
   localparam logic [ADDR_W-1:0] A_RESP = ADDR_W'(3);
   localparam logic [ADDR_W-1:0] A_DBG  = ADDR_W'(4);

   if (DATA_W != 16) begin : g_bad_data
      $error("win_watchdog: DATA_W must be 16");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("win_watchdog: ADDR_W must be at least 3");
   end

   logic             dbg_s;
   if (SYNC_DBG) begin : g_dbg_sync
      logic [1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '0;
         else        sync_q <= {sync_q[0], dbg_halt};
      end
      assign dbg_s = sync_q[1];
   end else begin : g_dbg_direct
      assign dbg_s = dbg_halt;
   end

   logic [15:0]      ctrl_q;
   logic             resp_q, dstop_q, run_q, uf_q, re_q;
   logic [CNT_W-1:0] cnt_q, reload;
   logic             wr_svc, wr_ctrl, wr_stat, wr_resp, wr_dbg;
   logic             seq_done, stray, legal, tick, frozen;
   logic             svc_ok, svc_bad, uf_evt;

   assign wr_svc  = bus_wr && (bus_addr == A_SVC);
   assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
   assign wr_stat = bus_wr && (bus_addr == A_STAT);
   assign wr_resp = bus_wr && (bus_addr == A_RESP);
   assign wr_dbg  = bus_wr && (bus_addr == A_DBG);

   assign reload = wwdt_reload(ctrl_q[1:0]);
   assign frozen = dstop_q || dbg_s;

   wwdt_refresh_seq i_seq (
      .clk(clk), .rst_n(rst_n), .wr_svc(wr_svc), .svc_byte(bus_wdata[7:0]),
      .seq_done(seq_done), .stray(stray)
   );

   wwdt_window #(.CNT_W(CNT_W)) i_win (
      .cnt(cnt_q), .reload(reload), .wst(ctrl_q[13:12]), .wend(ctrl_q[9:8]),
      .legal(legal)
   );

   assign svc_ok  = seq_done && (!run_q || legal);
   assign svc_bad = stray || (seq_done && run_q && !legal);

   wwdt_prescale #(.PRE_W(PRE_W)) i_pre (
      .clk(clk), .rst_n(rst_n), .clr(svc_ok),
      .en(run_q && cnt_tick && !frozen),
      .div_m1(wwdt_div_m1(ctrl_q[7:4])), .tick(tick)
   );

   assign uf_evt = tick && (cnt_q == '0) && !svc_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         resp_q  <= 1'b0;
         dstop_q <= 1'b0;
         run_q   <= 1'b0;
         cnt_q   <= '0;
         uf_q    <= 1'b0;
         re_q    <= 1'b0;
      end else begin
         if (wr_ctrl && !run_q) ctrl_q <= bus_wdata & CTRL_MASK;
         if (wr_resp)           resp_q <= bus_wdata[7];
         if (wr_dbg)            dstop_q <= bus_wdata[0];
         if (svc_ok)            run_q <= 1'b1;
         if (svc_ok)            cnt_q <= reload;
         else if (tick)         cnt_q <= (cnt_q == '0) ? reload : cnt_q - 1'b1;
         uf_q <= uf_evt  || (uf_q && (!wr_stat || bus_wdata[14]));
         re_q <= svc_bad || (re_q && (!wr_stat || bus_wdata[15]));
      end
   end

   always_comb begin
      case (bus_addr)
         A_CTRL:  bus_rdata = ctrl_q;
         A_STAT:  bus_rdata = {re_q, uf_q, cnt_q};
         A_RESP:  bus_rdata = {8'h00, resp_q, 7'h00};
         A_DBG:   bus_rdata = {15'h0000, dstop_q};
         default: bus_rdata = '0;
      endcase
   end

   assign rst_req = resp_q  && (uf_q || re_q);
   assign irq     = !resp_q && (uf_q || re_q);

   // R1: idle counter stays at zero until started
   a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |-> cnt_q == '0);
   // R7: a tick at zero raises the underflow flag and reloads
   a_r7_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt_q == '0 && !svc_ok) |=> (uf_q && cnt_q == $past(reload)));
   // R5: an out-of-window sequence leaves the count alone and flags
   a_r5_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_done && run_q && !legal && !tick) |=> ($stable(cnt_q) && re_q));
   // R10: frozen counter holds unless serviced
   a_r10_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && frozen && !svc_ok) |=> $stable(cnt_q));
   // R11: control locked while running
   a_r11_lock: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |=> $stable(ctrl_q));
   // R8: outputs mutually exclusive
   a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(rst_req && irq));
endmodule

// File: tb/test_win_watchdog.sv
`timescale 1ns/1ps
module test_win_watchdog;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        cnt_tick = 1'b0;
   logic        dbg_halt = 1'b0;
   logic        rst_req, irq;

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   win_watchdog i_win_watchdog (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_tick(cnt_tick),
      .dbg_halt(dbg_halt), .rst_req(rst_req), .irq(irq)
   );

   function automatic int exp_reload(int tops);
      case (tops)
         0: return 1023;
         1: return 4095;
         2: return 8191;
         default: return 16383;
      endcase
   endfunction

   // window test from percentages: start (S+1)*25%, end (3-E)*25%
   function automatic bit exp_legal(int cnt, int per, int s, int e);
      return (4 * cnt < per * (s + 1)) && (4 * cnt >= per * (3 - e));
   endfunction

   task automatic chk(string req, int act, int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(int a, int d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a[2:0]; bus_wdata = d[15:0];
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(int a, output int d);
      bus_addr = a[2:0];
      #1 d = int'(bus_rdata);
   endtask

   task automatic service();
      wr(0, 'h00);
      wr(0, 'hFF);
   endtask

   task automatic ticks(int n);
      @(negedge clk);
      cnt_tick = 1'b1;
      repeat (n) @(negedge clk);
      cnt_tick = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         n_vec++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      int s;
      void'($urandom(32'd20240611));
      do_reset();

      // R1 reset state and idle counter
      rd(2, s); chk("R1 status", s, 0);
      chk("R1 rst_req", int'(rst_req), 0);
      chk("R1 irq", int'(irq), 0);
      ticks(20);
      rd(2, s); chk("R1 idle count", s, 0);

      // R11 masked readback before start, lock after
      wr(1, 'hFFFF);
      rd(1, s); chk("R11 masked", s, 'h33F3);
      wr(1, 'h3300);
      service();
      rd(2, s); chk("R2 start load", s, 1023);
      wr(1, 'h0003);
      rd(1, s); chk("R11 locked", s, 'h3300);
      ticks(25);
      rd(2, s); chk("R2 decrement", s, 1023 - 25);

      // R2 period codes
      for (int t = 1; t < 4; t++) begin
         do_reset();
         wr(1, 'h3300 | t);
         service();
         rd(2, s); chk("R2 period code", s, exp_reload(t));
      end

      // R3 divider codes
      do_reset(); wr(1, 'h3340); service(); ticks(40);
      rd(2, s); chk("R3 div4", s, 1023 - 10);
      do_reset(); wr(1, 'h3350); service(); ticks(512);
      rd(2, s); chk("R3 div256", s, 1023 - 2);
      do_reset(); wr(1, 'h3380); service(); ticks(8192);
      rd(2, s); chk("R3 div8192", s, 1023 - 1);
      do_reset(); wr(1, 'h3310); service(); ticks(7);
      rd(2, s); chk("R3 other code div1", s, 1023 - 7);

      // R4/R5 random window trials at P=1024
      for (int k = 0; k < 16; k++) begin
         int ws, we, n, c;
         bit lg;
         ws = int'($urandom_range(0, 3));
         we = int'($urandom_range(0, 3));
         n  = int'($urandom_range(0, 1023));
         do_reset();
         wr(1, (ws << 12) | (we << 8));
         service();
         if (n > 0) ticks(n);
         c  = 1023 - n;
         lg = exp_legal(c, 1024, ws, we);
         service();
         rd(2, s);
         chk("R4 window count", s & 'h3FFF, lg ? 1023 : c);
         chk("R5 window flag", (s >> 15) & 1, lg ? 0 : 1);
      end

      // R4 directed edges: start 50% end 25% -> legal 256..511
      do_reset(); wr(1, 'h1200); service(); ticks(1023 - 511);
      service(); rd(2, s); chk("R4 top edge", s, 1023);
      do_reset(); wr(1, 'h1200); service(); ticks(1023 - 512);
      service(); rd(2, s); chk("R5 above edge", s, 'h8000 | 512);
      do_reset(); wr(1, 'h1200); service(); ticks(1023 - 255);
      service(); rd(2, s); chk("R5 below edge", s, 'h8000 | 255);

      // R5 empty window: start 25% end 75%
      do_reset(); wr(1, 'h0000); service(); ticks(500);
      service(); rd(2, s); chk("R5 empty window", s, 'h8000 | 523);
      chk("R8 irq on error", int'(irq), 1);

      // R6 stray FF writes
      do_reset(); wr(0, 'hFF);
      rd(2, s); chk("R6 bare FF", s, 'h8000);
      do_reset(); wr(0, 'h00); wr(0, 'h12); wr(0, 'hFF);
      rd(2, s); chk("R6 broken sequence", s, 'h8000);

      // R7 underflow, R8 routing, R9 clearing
      do_reset(); wr(1, 'h3300); service(); ticks(1023);
      rd(2, s); chk("R7 at zero", s, 0);
      ticks(1);
      rd(2, s); chk("R7 underflow", s, 'h4000 | 1023);
      chk("R8 irq", int'(irq), 1);
      chk("R8 no rst_req", int'(rst_req), 0);
      wr(3, 'h80);
      chk("R8 rst_req", int'(rst_req), 1);
      chk("R8 irq off", int'(irq), 0);
      wr(2, 'h4000);
      rd(2, s); chk("R9 keep on 1", (s >> 14) & 1, 1);
      wr(2, 'h0000);
      rd(2, s); chk("R9 clear on 0", (s >> 14) & 3, 0);
      chk("R9 rst_req low", int'(rst_req), 0);

      // R10 freeze by register and by pin
      do_reset(); wr(1, 'h3300); service(); ticks(10);
      wr(4, 1); ticks(50);
      rd(2, s); chk("R10 reg freeze", s, 1013);
      wr(4, 0); ticks(3);
      rd(2, s); chk("R10 resume", s, 1010);
      dbg_halt = 1'b1; ticks(5);
      rd(2, s); chk("R10 pin freeze", s, 1010);
      dbg_halt = 1'b0; ticks(2);
      rd(2, s); chk("R10 pin resume", s, 1008);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule